// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a fixed tree of three descriptor tables held in memory: a top table indexed by the highest address bits, a middle table, and a page table whose geometry depends on a page-size select (4 KiB or 8 KiB pages). One of two root pointers is chosen by the supervisor bit of the access's function code. Each walk is started with a single-cycle pulse. The walk then issues one 32-bit memory transaction at a time over a request/acknowledge port.

While it walks, the block keeps the tables' bookkeeping bits up to date. It sets the used bit on any descriptor it passes through, and it sets the modified bit on the page descriptor of a write. Each such update is a read-modify-write. The page descriptor is written back only when its value actually changed. Indirect page descriptors are followed. Write protection and supervisor-only pages are enforced.

A probe mode runs the same walk without touching memory and without raising protection faults. It reports whether any write-protect bit lay on the path. The result of each walk is a physical address or a bus-error flag, presented with a one-cycle `done` pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low.
- R2: The root descriptor address is the root pointer plus 4 times address bits 31:25. The supervisor root pointer is used when `is_super` is 1, and the user root pointer otherwise. The middle-table address is the root descriptor with bits 8:0 cleared, plus 4 times address bits 24:18.
- R3: With `page8k` = 0, the page index is address bits 17:12 and the page-table base is the middle descriptor with bits 7:0 cleared. With `page8k` = 1, the page index is bits 17:13 and the base is the middle descriptor with bits 6:0 cleared. In both cases the page descriptor address is the base plus 4 times the index.
- R4: On success, `paddr` is the page descriptor with its offset bits cleared (bits 11:0 for 4 KiB, bits 12:0 for 8 KiB), ORed with the same offset bits of the logical address.
- R5: A root or middle descriptor with bit 1 clear ends the walk with `bus_err` = 1, and nothing is written.
- R6: Outside probe mode, a valid root or middle descriptor with used bit 3 clear is written back to its own address with bit 3 set, before the next level is read.
- R7: A page descriptor of type 2 (bits 1:0) is indirect. The next descriptor is read from that value with bits 1:0 cleared. More than MAX_HOPS (default 4) indirections in a row give `bus_err`. A final type of 0 gives `bus_err`.
- R8: Outside probe mode, a write that meets write-protect bit 2 at any level gives `bus_err`. A page descriptor with bit 7 set, reached with `is_super` = 0, also gives `bus_err`. The faulting descriptor is not written back.
- R9: On a resident page (type 1 or 3), bit 3 is set, and bit 4 is also set for a write. The result is written back to the address the descriptor was fetched from, and only if it differs from the fetched value.
- R10: In probe mode no memory write is issued and protection faults are not raised. `wp_seen` is 1 when a write-protect bit was seen on any level of the path.
- R11: An error response (`mem_err` with `mem_ack`) ends the walk with `bus_err` = 1.
- R12: At most one transaction is open. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`.
- R13: `busy` is high from the cycle after `start` through the `done` cycle. `done` lasts one cycle, and the results hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| vaddr | input | 32 | Logical address to translate |
| is_super | input | 1 | Supervisor access (function-code bit 2) |
| is_write | input | 1 | Access is a write |
| probe | input | 1 | Side-effect-free probe walk |
| page8k | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB |
| sup_root | input | 32 | Supervisor root table pointer |
| usr_root | input | 32 | User root table pointer |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Walk ended in a fault |
| paddr | output | 32 | Physical address on success |
| wp_seen | output | 1 | A write-protect bit was on the path |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Transaction byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |

## Verification
A wrong level or wrong base register would show on the first bad `mem_addr` of the walk, at most a few cycles after `start`. That fetch comes long before `paddr` appears. A stale descriptor copy or a wrong probe flag shows as an extra or missing memory write, or a wrong write value, during the same walk. The bench therefore logs every write with its address and data. A lost fault decision or a stuck state shows at `done` as a wrong `bus_err` or `wp_seen`, or as a `done` pulse that never comes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ROOT,
        S_WB_ROOT,
        S_RD_PTR,
        S_WB_PTR,
        S_RD_PAGE,
        S_WB_PAGE,
        S_FIN
    } walk_state_e;

    typedef enum logic [1:0] {
        LV_ROOT,
        LV_PTR,
        LV_PAGE
    } level_e;

    localparam int unsigned BIT_VALID = 1;
    localparam int unsigned BIT_WP    = 2;
    localparam int unsigned BIT_USED  = 3;
    localparam int unsigned BIT_MOD   = 4;
    localparam int unsigned BIT_SUPER = 7;

    localparam logic [1:0] DT_INVALID  = 2'd0;
    localparam logic [1:0] DT_INDIRECT = 2'd2;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PG_IDX_W   = 6
) (
    input  level_e          level,
    input  logic [AW-1:0]   vaddr,
    input  logic [AW-1:0]   root_ptr,
    input  logic [AW-1:0]   tbl_desc,
    input  logic            big_page,
    output logic [AW-1:0]   fetch_addr,
    output logic [AW-1:0]   off_mask
);
    localparam int ROOT_LSB     = AW - ROOT_IDX_W;
    localparam int PTR_LSB      = ROOT_LSB - PTR_IDX_W;
    localparam int SM_OFF_W     = PTR_LSB - PG_IDX_W;
    localparam int BIG_OFF_W    = SM_OFF_W + 1;
    localparam int PTR_ALIGN    = PTR_IDX_W + 2;
    localparam int PG_ALIGN_SM  = PG_IDX_W + 2;
    localparam int PG_ALIGN_BIG = PG_ALIGN_SM - 1;

    localparam logic [AW-1:0] PTR_BASE_MASK = ~((AW'(1) << PTR_ALIGN) - AW'(1));
    localparam logic [AW-1:0] PG_MASK_SM    = ~((AW'(1) << PG_ALIGN_SM) - AW'(1));
    localparam logic [AW-1:0] PG_MASK_BIG   = ~((AW'(1) << PG_ALIGN_BIG) - AW'(1));
    localparam logic [AW-1:0] OFF_MASK_SM   = (AW'(1) << SM_OFF_W) - AW'(1);
    localparam logic [AW-1:0] OFF_MASK_BIG  = (AW'(1) << BIG_OFF_W) - AW'(1);

    logic [AW-1:0] base;
    logic [AW-1:0] index;

    always_comb begin
        case (level)
            LV_ROOT: begin
                base  = root_ptr;
                index = AW'(vaddr[AW-1:ROOT_LSB]);
            end
            LV_PTR: begin
                base  = tbl_desc & PTR_BASE_MASK;
                index = AW'(vaddr[ROOT_LSB-1:PTR_LSB]);
            end
            default: begin
                if (big_page) begin
                    base  = tbl_desc & PG_MASK_BIG;
                    index = AW'(vaddr[PTR_LSB-1:BIG_OFF_W]);
                end else begin
                    base  = tbl_desc & PG_MASK_SM;
                    index = AW'(vaddr[PTR_LSB-1:SM_OFF_W]);
                end
            end
        endcase
        fetch_addr = base + (index << 2);
        off_mask   = big_page ? OFF_MASK_BIG : OFF_MASK_SM;
    end

endmodule

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
    import ptw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] desc,
    input  logic          is_write,
    output logic [1:0]    dtype,
    output logic          tbl_valid,
    output logic          wprot,
    output logic          super_only,
    output logic          used,
    output logic [DW-1:0] used_set,
    output logic [DW-1:0] marked
);
    localparam logic [DW-1:0] USED_BIT = DW'(1) << BIT_USED;
    localparam logic [DW-1:0] MOD_BIT  = DW'(1) << BIT_MOD;

    always_comb begin
        dtype      = desc[1:0];
        tbl_valid  = desc[BIT_VALID];
        wprot      = desc[BIT_WP];
        super_only = desc[BIT_SUPER];
        used       = desc[BIT_USED];
        used_set   = desc | USED_BIT;
        marked     = desc | USED_BIT | (is_write ? MOD_BIT : '0);
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PG_IDX_W   = 6,
    parameter int MAX_HOPS   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] vaddr,
    input  logic          is_super,
    input  logic          is_write,
    input  logic          probe,
    input  logic          page8k,
    input  logic [AW-1:0] sup_root,
    input  logic [AW-1:0] usr_root,
    output logic          busy,
    output logic          done,
    output logic          bus_err,
    output logic [AW-1:0] paddr,
    output logic          wp_seen,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    input  logic          mem_err
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);
    localparam logic [AW-1:0] TYPE_CLR = ~AW'(3);

    typedef struct packed {
        walk_state_e     st;
        logic [AW-1:0]   va;
        logic            sup;
        logic            wr;
        logic            prb;
        logic            big;
        logic [AW-1:0]   maddr;
        logic [AW-1:0]   wdat;
        logic [AW-1:0]   desc;
        logic [HOP_W-1:0] hops;
        logic            wp;
        logic [AW-1:0]   pa;
        logic            berr;
    } regs_t;

    regs_t q, d;

    level_e        gen_level;
    logic [AW-1:0] gen_va;
    logic [AW-1:0] gen_root;
    logic [AW-1:0] gen_desc;
    logic          gen_big;
    logic [AW-1:0] fetch_addr;
    logic [AW-1:0] off_mask;

    logic [1:0]    d_type;
    logic          d_valid;
    logic          d_wp;
    logic          d_super;
    logic          d_used;
    logic [AW-1:0] d_used_set;
    logic [AW-1:0] d_marked;

    always_comb begin
        case (q.st)
            S_IDLE:              gen_level = LV_ROOT;
            S_RD_ROOT, S_WB_ROOT: gen_level = LV_PTR;
            default:             gen_level = LV_PAGE;
        endcase
        gen_va   = (q.st == S_IDLE) ? vaddr : q.va;
        gen_big  = (q.st == S_IDLE) ? page8k : q.big;
        gen_root = is_super ? sup_root : usr_root;
        gen_desc = (q.st == S_RD_ROOT || q.st == S_RD_PTR) ? mem_rdata : q.desc;
    end

    ptw_addr_gen #(
        .AW(AW), .ROOT_IDX_W(ROOT_IDX_W), .PTR_IDX_W(PTR_IDX_W), .PG_IDX_W(PG_IDX_W)
    ) u_addr (
        .level(gen_level),
        .vaddr(gen_va),
        .root_ptr(gen_root),
        .tbl_desc(gen_desc),
        .big_page(gen_big),
        .fetch_addr(fetch_addr),
        .off_mask(off_mask)
    );

    ptw_desc_eval #(.DW(AW)) u_eval (
        .desc(mem_rdata),
        .is_write(q.wr),
        .dtype(d_type),
        .tbl_valid(d_valid),
        .wprot(d_wp),
        .super_only(d_super),
        .used(d_used),
        .used_set(d_used_set),
        .marked(d_marked)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_RD_ROOT;
                    d.va    = vaddr;
                    d.sup   = is_super;
                    d.wr    = is_write;
                    d.prb   = probe;
                    d.big   = page8k;
                    d.maddr = fetch_addr;
                    d.wdat  = '0;
                    d.desc  = '0;
                    d.hops  = '0;
                    d.wp    = 1'b0;
                    d.pa    = '0;
                    d.berr  = 1'b0;
                end
            end
            S_RD_ROOT, S_RD_PTR: begin
                if (mem_ack) begin
                    if (mem_err || !d_valid) begin
                        d.st   = S_FIN;
                        d.berr = 1'b1;
                    end else begin
                        d.wp = q.wp | d_wp;
                        if (d_wp && q.wr && !q.prb) begin
                            d.st   = S_FIN;
                            d.berr = 1'b1;
                        end else if (!d_used && !q.prb) begin
                            d.st   = (q.st == S_RD_ROOT) ? S_WB_ROOT : S_WB_PTR;
                            d.wdat = d_used_set;
                            d.desc = d_used_set;
                        end else begin
                            d.st    = (q.st == S_RD_ROOT) ? S_RD_PTR : S_RD_PAGE;
                            d.maddr = fetch_addr;
                            d.desc  = mem_rdata;
                        end
                    end
                end
            end
            S_WB_ROOT, S_WB_PTR: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st   = S_FIN;
                        d.berr = 1'b1;
                    end else begin
                        d.st    = (q.st == S_WB_ROOT) ? S_RD_PTR : S_RD_PAGE;
                        d.maddr = fetch_addr;
                    end
                end
            end
            S_RD_PAGE: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st   = S_FIN;
                        d.berr = 1'b1;
                    end else if (d_type == DT_INDIRECT) begin
                        if (q.hops == HOP_W'(MAX_HOPS)) begin
                            d.st   = S_FIN;
                            d.berr = 1'b1;
                        end else begin
                            d.hops  = q.hops + HOP_W'(1);
                            d.maddr = mem_rdata & TYPE_CLR;
                        end
                    end else if (d_type == DT_INVALID) begin
                        d.st   = S_FIN;
                        d.berr = 1'b1;
                    end else begin
                        d.wp = q.wp | d_wp;
                        if (!q.prb && ((d_wp && q.wr) || (d_super && !q.sup))) begin
                            d.st   = S_FIN;
                            d.berr = 1'b1;
                        end else begin
                            d.pa = (mem_rdata & ~off_mask) | (q.va & off_mask);
                            if (!q.prb && (d_marked != mem_rdata)) begin
                                d.st   = S_WB_PAGE;
                                d.wdat = d_marked;
                            end else begin
                                d.st = S_FIN;
                            end
                        end
                    end
                end
            end
            S_WB_PAGE: begin
                if (mem_ack) begin
                    d.st = S_FIN;
                    if (mem_err) d.berr = 1'b1;
                end
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy      = (q.st != S_IDLE);
        done      = (q.st == S_FIN);
        bus_err   = q.berr;
        paddr     = q.pa;
        wp_seen   = q.wp;
        mem_req   = (q.st == S_RD_ROOT) || (q.st == S_WB_ROOT) || (q.st == S_RD_PTR) ||
                    (q.st == S_WB_PTR)  || (q.st == S_RD_PAGE) || (q.st == S_WB_PAGE);
        mem_we    = (q.st == S_WB_ROOT) || (q.st == S_WB_PTR) || (q.st == S_WB_PAGE);
        mem_addr  = q.maddr;
        mem_wdata = q.wdat;
    end

    // R12: an open transaction keeps its request and payload until acknowledged
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10: a probe walk never drives a write
    a_r10_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy && q.prb |-> !mem_we);

    // R13: completion is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: a walk opens with a read of the root level
    a_r13_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req && !mem_we);

    // R11: an error response ends the walk with a fault
    a_r11_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> done && bus_err);

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic        is_super = 1'b0;
    logic        is_write = 1'b0;
    logic        probe = 1'b0;
    logic        page8k = 1'b0;
    logic [31:0] sup_root = 32'h1800;
    logic [31:0] usr_root = 32'h1000;
    logic        busy, done, bus_err, wp_seen;
    logic [31:0] paddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .is_super(is_super), .is_write(is_write), .probe(probe), .page8k(page8k),
        .sup_root(sup_root), .usr_root(usr_root),
        .busy(busy), .done(done), .bus_err(bus_err), .paddr(paddr), .wp_seen(wp_seen),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // memory model: one-cycle acknowledge, write log
    logic [31:0] mem [logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          wcnt = 0;
    logic [31:0] wlog_a [64];
    logic [31:0] wlog_d [64];
    int          viol = 0;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_err   <= (mem_addr == err_addr);
            mem_rdata <= mrd(mem_addr);
            if (mem_we) begin
                wlog_a[wcnt % 64] <= mem_addr;
                wlog_d[wcnt % 64] <= mem_wdata;
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // R12 protocol monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
            prev_wait <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [31:0] r_pa;
    logic        r_be, r_wp, r_busy1, r_done_after, r_busy_after;
    int          w0, wdelta;

    localparam logic [31:0] VA = 32'h0284_5ABC;

    task automatic walk(input logic [31:0] va, input logic sup, input logic wr,
                        input logic prb, input logic big);
        int n;
        @(negedge clk);
        vaddr = va; is_super = sup; is_write = wr; probe = prb; page8k = big;
        w0 = wcnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_busy1 = busy;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        r_pa = paddr; r_be = bus_err; r_wp = wp_seen;
        @(negedge clk);
        r_done_after = done; r_busy_after = busy;
        wdelta = wcnt - w0;
    endtask

    task automatic base_tables();
        mem.delete();
        mem[32'h1004] = 32'h0000_200A;
        mem[32'h2084] = 32'h0000_310A;
        mem[32'h3114] = 32'h0055_5009;
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
    endtask

    task automatic t_read_4k();
        base_tables();
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4", "paddr 4k", r_pa, 32'h0055_5ABC);
        chk("R2", "no fault", 32'(r_be), 32'd0);
        chk("R9", "unchanged page not written", 32'(wdelta), 32'd0);
        chk("R13", "busy after start", 32'(r_busy1), 32'd1);
        chk("R13", "done one cycle", 32'(r_done_after), 32'd0);
        chk("R13", "idle after done", 32'(r_busy_after), 32'd0);
        repeat (3) @(negedge clk);
        chk("R13", "paddr held", paddr, 32'h0055_5ABC);
    endtask

    task automatic t_write_mod();
        base_tables();
        walk(VA, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9", "paddr", r_pa, 32'h0055_5ABC);
        chk("R9", "one write", 32'(wdelta), 32'd1);
        chk("R9", "write addr", wlog_a[w0 % 64], 32'h0000_3114);
        chk("R9", "write data", wlog_d[w0 % 64], 32'h0055_5019);
    endtask

    task automatic t_used_sup();
        mem.delete();
        mem[32'h1804] = 32'h0000_2002;
        mem[32'h2084] = 32'h0000_3102;
        mem[32'h3114] = 32'h0055_5009;
        walk(VA, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2", "sup root paddr", r_pa, 32'h0055_5ABC);
        chk("R6", "two writes", 32'(wdelta), 32'd2);
        chk("R6", "root wb addr", wlog_a[w0 % 64], 32'h0000_1804);
        chk("R6", "root wb data", wlog_d[w0 % 64], 32'h0000_200A);
        chk("R6", "ptr wb addr", wlog_a[(w0 + 1) % 64], 32'h0000_2084);
        chk("R6", "ptr wb data", wlog_d[(w0 + 1) % 64], 32'h0000_310A);
    endtask

    task automatic t_big_page();
        mem.delete();
        mem[32'h1004] = 32'h0000_200A;
        mem[32'h2084] = 32'h0000_318A;
        mem[32'h3188] = 32'h0077_6009;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3", "8k paddr", r_pa, 32'h0077_7ABC);
        chk("R3", "8k fault", 32'(r_be), 32'd0);
    endtask

    task automatic t_indirect();
        base_tables();
        mem[32'h3114] = 32'h0000_4002;
        mem[32'h4000] = 32'h0000_4102;
        mem[32'h4100] = 32'h0088_8009;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", "indirect paddr", r_pa, 32'h0088_8ABC);
        chk("R7", "indirect no write", 32'(wdelta), 32'd0);
        walk(VA, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9", "indirect wb addr", wlog_a[w0 % 64], 32'h0000_4100);
        chk("R9", "indirect wb data", wlog_d[w0 % 64], 32'h0088_8019);
        mem[32'h3114] = 32'h0000_3116;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", "indirect loop fault", 32'(r_be), 32'd1);
        mem[32'h3114] = 32'h0055_5008;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", "type0 fault", 32'(r_be), 32'd1);
    endtask

    task automatic t_invalid();
        base_tables();
        mem[32'h1004] = 32'h0000_2008;
        walk(VA, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5", "root invalid fault", 32'(r_be), 32'd1);
        chk("R5", "root invalid no write", 32'(wdelta), 32'd0);
        base_tables();
        mem[32'h2084] = 32'h0000_3100;
        walk(VA, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5", "ptr invalid fault", 32'(r_be), 32'd1);
        chk("R5", "ptr invalid no write", 32'(wdelta), 32'd0);
    endtask

    task automatic t_protect();
        base_tables();
        mem[32'h2084] = 32'h0000_310E;
        walk(VA, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8", "wp write fault", 32'(r_be), 32'd1);
        chk("R8", "wp write no wb", 32'(wdelta), 32'd0);
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8", "wp read ok", 32'(r_be), 32'd0);
        chk("R8", "wp read paddr", r_pa, 32'h0055_5ABC);
        base_tables();
        mem[32'h3114] = 32'h0055_5081;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8", "super page user fault", 32'(r_be), 32'd1);
        chk("R8", "super page no wb", 32'(wdelta), 32'd0);
        mem[32'h1804] = 32'h0000_200A;
        walk(VA, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8", "super page sup ok", 32'(r_be), 32'd0);
        chk("R9", "used bit set", wlog_d[w0 % 64], 32'h0055_5089);
    endtask

    task automatic t_probe();
        base_tables();
        mem[32'h1004] = 32'h0000_2006;
        mem[32'h3114] = 32'h0055_5001;
        walk(VA, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10", "probe no writes", 32'(wdelta), 32'd0);
        chk("R10", "probe no fault", 32'(r_be), 32'd0);
        chk("R10", "probe wp seen", 32'(r_wp), 32'd1);
        chk("R10", "probe paddr", r_pa, 32'h0055_5ABC);
        base_tables();
        walk(VA, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10", "probe clean wp", 32'(r_wp), 32'd0);
    endtask

    task automatic t_mem_err();
        base_tables();
        err_addr = 32'h0000_2084;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11", "error response fault", 32'(r_be), 32'd1);
        chk("R11", "error no write", 32'(wdelta), 32'd0);
        err_addr = 32'hFFFF_FFFF;
        walk(VA, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11", "recovers after error", 32'(r_be), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_4k();
        t_write_mod();
        t_used_sup();
        t_big_page();
        t_indirect();
        t_invalid();
        t_protect();
        t_probe();
        t_mem_err();
        chk("R12", "protocol violations", 32'(viol), 32'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule